// File: doc/BRIEF.md
# Transactional line tracker

This block follows which lines of a small private data cache belong to an open transaction of either of two hardware threads. Each thread opens, closes or cancels its transaction with per-thread commands. Loads and stores carry a thread number and a line index. The block records them in per-thread read-set and write-set masks. Snoops from other agents and accesses from the other thread are compared against those masks. A hit ends the victim's transaction with an abort. Lines in any set are pinned: the cache's replacement logic may not take them, and asking for one aborts the owners.

Speculative stores stay in the private line while the next level keeps the line's previous value. When a line that is already dirty receives its first speculative store, the block asks for a write-back of the clean copy. A commit clears the committing thread's masks in one cycle, so all its stores become visible together. An abort invalidates every line the thread wrote and reports why it ended. The cache's data storage and coherence states are outside this block. Only per-line valid and dirty flags are kept.

Top module: `txn_line_tracker`

## Requirements
- R1: A load by a thread with an open transaction adds the line to that thread's read set. A store adds it to the thread's write set. Any access marks the line valid, and a store also marks it dirty. An access by a thread with no open transaction adds nothing to any set.
- R2: `beginCmd[t]` opens a transaction for thread t when none is open; a second begin while open has no effect. `endCmd` or `abortCmd` for a thread with no open transaction has no effect. `txActive[t]` shows whether thread t has an open transaction.
- R3: `endCmd[t]` on an open transaction with no abort condition in the same cycle gives a one-cycle `commitStrobe[t]`. It clears all of thread t's set bits, and lines it wrote stay valid.
- R4: Thread t aborts with cause 1 in two cases: a snoop write or a write by the other thread hits a line in t's read or write set, or a snoop read or a read by the other thread hits a line in t's write set. A snoop read of a read-set line is not a conflict.
- R5: A replacement request for a line in any thread's read or write set is refused (`rplGrant` low). Every thread holding that line aborts with cause 2.
- R6: On abort, every line in the aborting thread's write set becomes invalid, and its bits appear in the one-cycle `lineInvalidate` mask. `abortCmd` gives cause 0. When abort and end arrive together, the abort wins and no commit is signalled.
- R7: The first speculative store to a line that is valid and dirty, and in no thread's write set, raises `wbValid` with `wbLine` equal to that line. Later stores by the same transaction to that line raise no write-back.
- R8: A replacement request for a line in no set is granted and the line becomes invalid. If the line was valid and dirty, a write-back of it is requested. It is refused when an access targets the same line or a store write-back is raised in the same cycle.
- R9: `abortCause` holds thread 0's code in bits [1:0] and thread 1's in bits [3:2]. The codes are 0 explicit, 1 conflict, 2 capacity. A field is 0 whenever that thread's `abortStrobe` is low.
- R10: All strobes, output registers, set bits and line flags are cleared by reset (`rst_n` low). Every output strobe appears on the clock edge that samples its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beginCmd | input | 2 | Per-thread transaction begin |
| endCmd | input | 2 | Per-thread transaction end |
| abortCmd | input | 2 | Per-thread explicit abort |
| accValid | input | 1 | Load or store request present |
| accWrite | input | 1 | Request is a store |
| accThread | input | 1 | Issuing thread |
| accLine | input | LINE_W | Line index of the request |
| snpValid | input | 1 | External snoop present |
| snpWrite | input | 1 | Snoop is a write |
| snpLine | input | LINE_W | Snooped line index |
| rplValid | input | 1 | Replacement request from the cache |
| rplLine | input | LINE_W | Line chosen for replacement |
| commitStrobe | output | 2 | Per-thread commit pulse |
| abortStrobe | output | 2 | Per-thread abort pulse |
| abortCause | output | 4 | Per-thread abort code, two bits each |
| wbValid | output | 1 | Write-back to the shared level requested |
| wbLine | output | LINE_W | Line to write back |
| rplGrant | output | 1 | Replacement accepted |
| lineInvalidate | output | NUM_LINES | Lines discarded by an abort |
| lineValid | output | NUM_LINES | Per-line valid flags |
| txActive | output | 2 | Per-thread open transaction |

## Verification
A wrong set bit shows up on the cycle after the first snoop, other-thread access or replacement that tests that line. It appears as a spurious or missing `abortStrobe`, a wrong cause, or a granted eviction of a pinned line. A stale dirty flag shows up as a missing or extra `wbValid` on the next store or eviction of that line. A line kept valid after a discard shows in `lineValid` at once. The stimulus therefore opens sets, probes them from each side, and then probes them again after commit and abort to confirm they were emptied.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int NUM_THREADS = 2;

  typedef enum logic [1:0] {
    CAUSE_EXPLICIT = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_CAPACITY = 2'd2
  } abort_cause_e;

  // control -> datapath strobes, one bit per thread
  typedef struct packed {
    logic [NUM_THREADS-1:0] trackEn;    // thread has an open, surviving transaction
    logic [NUM_THREADS-1:0] clearSets;  // drop all set bits of the thread
    logic [NUM_THREADS-1:0] discard;    // invalidate lines in the thread's write set
  } ctrl_strobe_t;
endpackage

// File: rtl/txn_ctrl.sv
module txn_ctrl
  import txn_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_THREADS-1:0]     beginCmd,
  input  logic [NUM_THREADS-1:0]     endCmd,
  input  logic [NUM_THREADS-1:0]     abortCmd,
  input  logic [NUM_THREADS-1:0]     conflictHit,
  input  logic [NUM_THREADS-1:0]     capacityHit,
  output ctrl_strobe_t               strb,
  output logic [NUM_THREADS-1:0]     txActive,
  output logic [NUM_THREADS-1:0]     commitStrobe,
  output logic [NUM_THREADS-1:0]     abortStrobe,
  output logic [2*NUM_THREADS-1:0]   abortCause
);
  logic [NUM_THREADS-1:0]   activeQ;
  logic [NUM_THREADS-1:0]   activeN;
  logic [NUM_THREADS-1:0]   abortNow;
  logic [NUM_THREADS-1:0]   commitNow;
  logic [2*NUM_THREADS-1:0] causeN;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    abort_cause_e cause;

    assign abortNow[t]  = activeQ[t] & (abortCmd[t] | conflictHit[t] | capacityHit[t]);
    assign commitNow[t] = activeQ[t] & endCmd[t] & ~abortNow[t];

    // explicit request outranks conflict, conflict outranks capacity
    always_comb begin
      if (abortCmd[t])         cause = CAUSE_EXPLICIT;
      else if (conflictHit[t]) cause = CAUSE_CONFLICT;
      else                     cause = CAUSE_CAPACITY;
    end

    assign causeN[2*t +: 2] = abortNow[t] ? cause : CAUSE_EXPLICIT;

    always_comb begin
      if (abortNow[t] || commitNow[t]) activeN[t] = 1'b0;
      else if (!activeQ[t] && beginCmd[t]) activeN[t] = 1'b1;
      else activeN[t] = activeQ[t];
    end
  end

  assign strb.trackEn   = activeQ & ~abortNow;
  assign strb.clearSets = abortNow | commitNow;
  assign strb.discard   = abortNow;
  assign txActive       = activeQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ      <= '0;
      commitStrobe <= '0;
      abortStrobe  <= '0;
      abortCause   <= '0;
    end else begin
      activeQ      <= activeN;
      commitStrobe <= commitNow;
      abortStrobe  <= abortNow;
      abortCause   <= causeN;
    end
  end
endmodule

// File: rtl/txn_line_array.sv
module txn_line_array
  import txn_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_strobe_t            strb,
  input  logic                    accValid,
  input  logic                    accWrite,
  input  logic                    accThread,
  input  logic [LINE_W-1:0]       accLine,
  input  logic                    snpValid,
  input  logic                    snpWrite,
  input  logic [LINE_W-1:0]       snpLine,
  input  logic                    rplValid,
  input  logic [LINE_W-1:0]       rplLine,
  output logic [NUM_THREADS-1:0]  conflictHit,
  output logic [NUM_THREADS-1:0]  capacityHit,
  output logic                    wbValid,
  output logic [LINE_W-1:0]       wbLine,
  output logic                    rplGrant,
  output logic [NUM_LINES-1:0]    lineInvalidate,
  output logic [NUM_LINES-1:0]    lineValid
);
  logic [NUM_THREADS-1:0][NUM_LINES-1:0] rsQ, wsQ, rsN, wsN, setT;
  logic [NUM_LINES-1:0] validQ, validN, dirtyQ, dirtyN, discardMask, anyWs, pinned;
  logic [NUM_THREADS-1:0] otherAcc, ownAcc;
  logic storeWb, grantNow, evictWb, wbNow;
  logic [LINE_W-1:0] wbLineN;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    assign setT[t]     = rsQ[t] | wsQ[t];
    assign otherAcc[t] = accValid && (accThread != 1'(t));
    assign ownAcc[t]   = accValid && (accThread == 1'(t)) && strb.trackEn[t];

    assign conflictHit[t] =
        (snpValid && (snpWrite ? setT[t][snpLine] : wsQ[t][snpLine])) ||
        (otherAcc[t] && (accWrite ? setT[t][accLine] : wsQ[t][accLine]));
    assign capacityHit[t] = rplValid && setT[t][rplLine];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic hitHere;
      assign hitHere    = ownAcc[t] && (accLine == LINE_W'(l));
      assign rsN[t][l]  = strb.clearSets[t] ? 1'b0 : (rsQ[t][l] | (hitHere & ~accWrite));
      assign wsN[t][l]  = strb.clearSets[t] ? 1'b0 : (wsQ[t][l] | (hitHere &  accWrite));
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic accHere, evictHere;
    logic [NUM_THREADS-1:0] wsCol, setCol;
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_col
      assign wsCol[t]  = wsQ[t][l];
      assign setCol[t] = setT[t][l];
    end
    assign anyWs[l]       = |wsCol;
    assign pinned[l]      = |setCol;
    assign discardMask[l] = |(strb.discard & wsCol);
    assign accHere        = accValid && (accLine == LINE_W'(l));
    assign evictHere      = grantNow && (rplLine == LINE_W'(l));

    // speculative data of an aborted writer is dropped even if touched now
    always_comb begin
      if (discardMask[l]) begin
        validN[l] = 1'b0;
        dirtyN[l] = 1'b0;
      end else if (accHere) begin
        validN[l] = 1'b1;
        dirtyN[l] = dirtyQ[l] | accWrite;
      end else if (evictHere) begin
        validN[l] = 1'b0;
        dirtyN[l] = 1'b0;
      end else begin
        validN[l] = validQ[l];
        dirtyN[l] = dirtyQ[l];
      end
    end
  end

  // clean copy must reach the shared level before the first speculative store
  assign storeWb  = accValid && accWrite && strb.trackEn[accThread] &&
                    validQ[accLine] && dirtyQ[accLine] && !anyWs[accLine];
  assign grantNow = rplValid && !pinned[rplLine] && !storeWb &&
                    !(accValid && (accLine == rplLine));
  assign evictWb  = grantNow && validQ[rplLine] && dirtyQ[rplLine];
  assign wbNow    = storeWb || evictWb;
  assign wbLineN  = storeWb ? accLine : rplLine;

  assign lineValid = validQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsQ            <= '0;
      wsQ            <= '0;
      validQ         <= '0;
      dirtyQ         <= '0;
      wbValid        <= 1'b0;
      wbLine         <= '0;
      rplGrant       <= 1'b0;
      lineInvalidate <= '0;
    end else begin
      rsQ            <= rsN;
      wsQ            <= wsN;
      validQ         <= validN;
      dirtyQ         <= dirtyN;
      wbValid        <= wbNow;
      wbLine         <= wbNow ? wbLineN : '0;
      rplGrant       <= grantNow;
      lineInvalidate <= discardMask;
    end
  end
endmodule

// File: rtl/txn_line_tracker.sv
module txn_line_tracker
  import txn_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             beginCmd,
  input  logic [1:0]             endCmd,
  input  logic [1:0]             abortCmd,
  input  logic                   accValid,
  input  logic                   accWrite,
  input  logic                   accThread,
  input  logic [LINE_W-1:0]      accLine,
  input  logic                   snpValid,
  input  logic                   snpWrite,
  input  logic [LINE_W-1:0]      snpLine,
  input  logic                   rplValid,
  input  logic [LINE_W-1:0]      rplLine,
  output logic [1:0]             commitStrobe,
  output logic [1:0]             abortStrobe,
  output logic [3:0]             abortCause,
  output logic                   wbValid,
  output logic [LINE_W-1:0]      wbLine,
  output logic                   rplGrant,
  output logic [NUM_LINES-1:0]   lineInvalidate,
  output logic [NUM_LINES-1:0]   lineValid,
  output logic [1:0]             txActive
);
  ctrl_strobe_t strb;
  logic [NUM_THREADS-1:0] conflictHit, capacityHit;

  txn_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .beginCmd     (beginCmd),
    .endCmd       (endCmd),
    .abortCmd     (abortCmd),
    .conflictHit  (conflictHit),
    .capacityHit  (capacityHit),
    .strb         (strb),
    .txActive     (txActive),
    .commitStrobe (commitStrobe),
    .abortStrobe  (abortStrobe),
    .abortCause   (abortCause)
  );

  txn_line_array #(.NUM_LINES(NUM_LINES)) u_array (
    .clk            (clk),
    .rst_n          (rst_n),
    .strb           (strb),
    .accValid       (accValid),
    .accWrite       (accWrite),
    .accThread      (accThread),
    .accLine        (accLine),
    .snpValid       (snpValid),
    .snpWrite       (snpWrite),
    .snpLine        (snpLine),
    .rplValid       (rplValid),
    .rplLine        (rplLine),
    .conflictHit    (conflictHit),
    .capacityHit    (capacityHit),
    .wbValid        (wbValid),
    .wbLine         (wbLine),
    .rplGrant       (rplGrant),
    .lineInvalidate (lineInvalidate),
    .lineValid      (lineValid)
  );
endmodule

// File: rtl/txn_line_tracker_chk.sv
module txn_line_tracker_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           beginCmd,
  input logic                 accValid,
  input logic                 accWrite,
  input logic                 rplValid,
  input logic [1:0]           commitStrobe,
  input logic [1:0]           abortStrobe,
  input logic [3:0]           abortCause,
  input logic                 wbValid,
  input logic                 rplGrant,
  input logic [NUM_LINES-1:0] lineInvalidate,
  input logic [NUM_LINES-1:0] lineValid,
  input logic [1:0]           txActive
);
  for (genvar t = 0; t < 2; t++) begin : g_thr
    p_open_needs_begin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txActive[t]) |-> $past(beginCmd[t]));
    p_abort_from_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      abortStrobe[t] |-> $past(txActive[t]));
    p_commit_from_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commitStrobe[t] |-> $past(txActive[t]) && !txActive[t]);
    p_cause_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      abortCause[2*t +: 2] != 2'd3);
    p_cause_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !abortStrobe[t] |-> abortCause[2*t +: 2] == 2'd0);
  end

  p_no_dual_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commitStrobe & abortStrobe) == 2'b00);
  p_inval_is_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lineInvalidate != '0) |-> (abortStrobe != 2'b00) && ((lineInvalidate & lineValid) == '0));
  p_grant_requested_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rplGrant |-> $past(rplValid));
  p_wb_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> $past(accValid && accWrite) || $past(rplValid));
endmodule

bind txn_line_tracker txn_line_tracker_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .beginCmd       (beginCmd),
  .accValid       (accValid),
  .accWrite       (accWrite),
  .rplValid       (rplValid),
  .commitStrobe   (commitStrobe),
  .abortStrobe    (abortStrobe),
  .abortCause     (abortCause),
  .wbValid        (wbValid),
  .rplGrant       (rplGrant),
  .lineInvalidate (lineInvalidate),
  .lineValid      (lineValid),
  .txActive       (txActive)
);

// File: tb/txn_line_tracker_tb_top.sv
module txn_line_tracker_tb_top;
  localparam int NL = 8;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] beginCmd = '0, endCmd = '0, abortCmd = '0;
  logic accValid = 0, accWrite = 0, accThread = 0;
  logic [LW-1:0] accLine = '0;
  logic snpValid = 0, snpWrite = 0;
  logic [LW-1:0] snpLine = '0;
  logic rplValid = 0;
  logic [LW-1:0] rplLine = '0;
  logic [1:0] commitStrobe, abortStrobe, txActive;
  logic [3:0] abortCause;
  logic wbValid, rplGrant;
  logic [LW-1:0] wbLine;
  logic [NL-1:0] lineInvalidate, lineValid;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;  // 125 MHz

  txn_line_tracker #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .beginCmd(beginCmd), .endCmd(endCmd), .abortCmd(abortCmd),
    .accValid(accValid), .accWrite(accWrite), .accThread(accThread), .accLine(accLine),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpLine(snpLine),
    .rplValid(rplValid), .rplLine(rplLine),
    .commitStrobe(commitStrobe), .abortStrobe(abortStrobe), .abortCause(abortCause),
    .wbValid(wbValid), .wbLine(wbLine), .rplGrant(rplGrant),
    .lineInvalidate(lineInvalidate), .lineValid(lineValid), .txActive(txActive)
  );

  typedef struct packed {
    logic [1:0] beg, fin, abt;
    logic accV, accW, accT;
    logic [2:0] accL;
    logic snpV, snpW;
    logic [2:0] snpL;
    logic rplV;
    logic [2:0] rplL;
    logic [1:0] eCommit, eAbort;
    logic [3:0] eCause;
    logic eWb;
    logic [2:0] eWbL;
    logic eGrant;
    logic [7:0] eInval;
    logic [1:0] eActive;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 38;
  // beg fin abt | accV accW accT accL | snpV snpW snpL | rplV rplL || commit abort cause wb wbL grant inval active | req
  localparam vec_t VEC [NV] = '{
    '{2'd0,2'd0,2'd0, 1,0,0,3'd2, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd1},  // R1 untracked load L2
    '{2'd1,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd2},  // R2 open T0
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 1,1,3'd2, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd1},  // R1 L2 not in set
    '{2'd0,2'd0,2'd0, 1,0,0,3'd3, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd1},  // R1 tx load L3
    '{2'd1,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd2},  // R2 second begin
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 1,0,3'd3, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd4},  // R4 snoop read of read set
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 1,1,3'd3, 0,3'd0, 2'd0,2'd1,4'h1,0,3'd0,0,8'h00,2'd0, 8'd4},  // R4 snoop write of read set
    '{2'd1,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd2},
    '{2'd0,2'd0,2'd0, 1,1,0,3'd4, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd7},  // R7 clean line, no wb
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 1,3'd4, 2'd0,2'd1,4'h2,0,3'd0,0,8'h10,2'd0, 8'd5},  // R5 pinned replacement
    '{2'd0,2'd0,2'd0, 1,1,0,3'd5, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd1},  // R1 untracked store L5
    '{2'd1,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd2},
    '{2'd0,2'd0,2'd0, 1,1,0,3'd5, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,1,3'd5,0,8'h00,2'd1, 8'd7},  // R7 first store to dirty
    '{2'd0,2'd0,2'd0, 1,1,0,3'd5, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd7},  // R7 no repeat
    '{2'd0,2'd1,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd1,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd3},  // R3 commit
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 1,3'd5, 2'd0,2'd0,4'h0,1,3'd5,1,8'h00,2'd0, 8'd8},  // R8 evict dirty committed
    '{2'd3,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd3, 8'd2},
    '{2'd0,2'd0,2'd0, 1,0,1,3'd6, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd3, 8'd1},
    '{2'd0,2'd0,2'd0, 1,1,0,3'd6, 0,0,3'd0, 0,3'd0, 2'd0,2'd2,4'h4,0,3'd0,0,8'h00,2'd1, 8'd9},  // R9 T1 cause field
    '{2'd0,2'd0,2'd0, 1,0,1,3'd6, 0,0,3'd0, 0,3'd0, 2'd0,2'd1,4'h1,0,3'd0,0,8'h40,2'd0, 8'd4},  // R4 other read of write set
    '{2'd3,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd3, 8'd2},
    '{2'd0,2'd0,2'd0, 1,0,0,3'd7, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd3, 8'd1},
    '{2'd0,2'd0,2'd2, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd2,4'h0,0,3'd0,0,8'h00,2'd1, 8'd6},  // R6 explicit abort
    '{2'd0,2'd1,2'd1, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd1,4'h0,0,3'd0,0,8'h00,2'd0, 8'd6},  // R6 abort beats end
    '{2'd0,2'd1,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd2},  // R2 end when closed
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 1,3'd7, 2'd0,2'd0,4'h0,0,3'd0,1,8'h00,2'd0, 8'd8},  // R8 clean eviction
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 1,3'd0, 2'd0,2'd0,4'h0,0,3'd0,1,8'h00,2'd0, 8'd8},
    '{2'd2,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd2, 8'd2},
    '{2'd0,2'd0,2'd0, 1,1,1,3'd1, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd2, 8'd1},
    '{2'd0,2'd0,2'd2, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd2,4'h0,0,3'd0,0,8'h02,2'd0, 8'd6},  // R6 discard write set
    '{2'd1,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd2},
    '{2'd0,2'd0,2'd0, 1,1,0,3'd2, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd1},
    '{2'd0,2'd0,2'd0, 0,0,0,3'd0, 1,0,3'd2, 0,3'd0, 2'd0,2'd1,4'h1,0,3'd0,0,8'h04,2'd0, 8'd4},  // R4 snoop read of write set
    '{2'd0,2'd0,2'd0, 1,0,1,3'd3, 0,0,3'd0, 1,3'd3, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd8},  // R8 same-line access
    '{2'd0,2'd0,2'd0, 1,1,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd1},
    '{2'd1,2'd0,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd0,2'd0,4'h0,0,3'd0,0,8'h00,2'd1, 8'd2},
    '{2'd0,2'd0,2'd0, 1,1,0,3'd0, 0,0,3'd0, 1,3'd3, 2'd0,2'd0,4'h0,1,3'd0,0,8'h00,2'd1, 8'd8},  // R8 store wb wins
    '{2'd0,2'd1,2'd0, 0,0,0,3'd0, 0,0,3'd0, 0,3'd0, 2'd1,2'd0,4'h0,0,3'd0,0,8'h00,2'd0, 8'd3}   // R3 commit
  };

  task automatic clearInputs();
    beginCmd = '0; endCmd = '0; abortCmd = '0;
    accValid = 0; accWrite = 0; accThread = 0; accLine = '0;
    snpValid = 0; snpWrite = 0; snpLine = '0;
    rplValid = 0; rplLine = '0;
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [31:0] actV, expV;
    clearInputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state before any active edge
    checkVal("R10 reset outputs",
             {30'd0, commitStrobe, abortStrobe, abortCause, wbValid, rplGrant, txActive},
             32'd0);
    checkVal("R10 reset lines", {24'd0, lineValid, lineInvalidate} , 32'd0);

    for (int i = 0; i < NV; i++) begin
      beginCmd = VEC[i].beg; endCmd = VEC[i].fin; abortCmd = VEC[i].abt;
      accValid = VEC[i].accV; accWrite = VEC[i].accW; accThread = VEC[i].accT; accLine = VEC[i].accL;
      snpValid = VEC[i].snpV; snpWrite = VEC[i].snpW; snpLine = VEC[i].snpL;
      rplValid = VEC[i].rplV; rplLine = VEC[i].rplL;
      @(negedge clk);
      actV = {9'd0, commitStrobe, abortStrobe, abortCause, wbValid, wbLine, rplGrant, lineInvalidate, txActive};
      expV = {9'd0, VEC[i].eCommit, VEC[i].eAbort, VEC[i].eCause, VEC[i].eWb, VEC[i].eWbL,
              VEC[i].eGrant, VEC[i].eInval, VEC[i].eActive};
      nChecks++;
      if (actV !== expV) begin
        nFails++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i].req, i, actV, expV);
      end
    end
    clearInputs();

    // R3 committed line L0 stays valid; R6/R8 discarded and evicted lines are gone
    checkVal("R3/R6/R8 lineValid after table", {24'd0, lineValid}, 32'h09);

    // R10: reset in the middle of an open transaction
    beginCmd = 2'b11;
    @(negedge clk);
    clearInputs();
    checkVal("R2 both open", {30'd0, txActive}, 32'd3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    checkVal("R10 txActive after reset", {30'd0, txActive}, 32'd0);
    checkVal("R10 lineValid after reset", {24'd0, lineValid}, 32'd0);
    // R1/R10: sets were emptied: snoop write to L3 aborts nobody
    beginCmd = 2'b01;
    @(negedge clk);
    beginCmd = 2'b00; snpValid = 1; snpWrite = 1; snpLine = 3'd3;
    @(negedge clk);
    clearInputs();
    checkVal("R10 sets cleared by reset", {30'd0, abortStrobe}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule